// File: doc/BRIEF.md
# SDRAM Bank Open-Row and Recovery Tracker

This block sits beside an SDRAM command scheduler and follows the command stream that the scheduler issues. For every bank it keeps a model of whether a row is open, which row that is, whether a read or write burst is still running, and whether the bank is waiting out its precharge recovery time. The scheduler uses the per-bank ready and open-row outputs to decide what it may legally send next.

Each read or write carries its own auto-precharge request. The block counts the burst down with a per-bank beat counter and closes the row when the burst ends. Full-page bursts run until something stops them, and auto-precharge has no effect on them. A burst-stop command cuts off whichever read or write was accepted most recently, and the row stays open. An explicit precharge closes a bank at once. Both kinds of precharge hold the bank busy for a parameterised number of recovery cycles. Commands that break the rules are dropped, and an error pulse reports them.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bank becomes closed and ready and `cmd_error` goes low.
- R2: ACTIVE (op 1) to a ready, closed bank opens it, and from the next cycle `open_row` for that bank shows the row given. ACTIVE to an already open bank changes nothing.
- R3: `burst_sel` values 0, 1, 2 and 3 select fixed bursts of 1, 2, 4 and 8 beats. Values 4 to 7 select full-page bursts. The length is captured when the READ or WRITE is accepted.
- R4: A READ (op 2) or WRITE (op 3) accepted at edge t with auto-precharge and fixed length L keeps the row open through edge t+L-1 and shows it closed after edge t+L. The bank is not ready from edge t until edge t+L+T_RP, and is ready after that edge.
- R5: A fixed-length READ or WRITE without auto-precharge leaves the row open and the bank ready after its burst.
- R6: Auto-precharge belongs only to the command that carried it. A later READ or WRITE without the flag to the reopened bank leaves its row open.
- R7: In full-page mode the auto-precharge flag is ignored. The burst keeps running, the row stays open and the bank stays ready.
- R8: BURST TERMINATE (op 4) ends only the burst of the most recently accepted READ or WRITE, whichever bank that is. It never closes a row, it cancels that burst's pending auto-precharge, and that bank is ready in the next cycle.
- R9: PRECHARGE (op 5) to a ready, open bank closes it, even during a burst. The bank is then not ready for T_RP cycles. PRECHARGE to a ready, closed bank has no effect.
- R10: `cmd_error` is high for exactly the cycle after a command is accepted in either of these cases: an ACTIVE, READ, WRITE or PRECHARGE to a bank that is not ready, or a READ or WRITE to a closed bank. Such a command has no effect. BURST TERMINATE and NOP (op 0) never raise it.
- R11: A READ or WRITE to a bank whose burst is still running without auto-precharge restarts the burst with the new command's length and auto-precharge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 BURST TERMINATE, 5 PRECHARGE, 6 and 7 treated as NOP |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row for ACTIVE |
| cmd_auto_pre | input | 1 | Auto-precharge request for READ or WRITE |
| burst_sel | input | 3 | Burst length select |
| bank_open | output | NUM_BANKS | One bit per bank, high while a row is open |
| open_row | output | NUM_BANKS*ROW_W | Open row of bank b at bits b*ROW_W and up |
| bank_ready | output | NUM_BANKS | Bank may accept a new command |
| cmd_error | output | 1 | Previous command was illegal and was dropped |

## Verification
The hardest case to reach is a burst stop that must hit the right bank while another bank has an auto-precharged burst still running. The stimulus opens two banks, starts an eight-beat auto-precharge read on one and then a plain read on the other in the next cycle, and issues the burst stop right after. The first bank must still close on its own schedule. A second case uses a burst stop against an auto-precharge burst to show that the row stays open and that the pending close is dropped.

// File: rtl/sdram_trk_pkg.sv
// Package: shared command encoding and burst-length decoding for the
// bank tracker. Assumes a 3-bit operation code and a 3-bit burst select.
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ACT   = 3'd1,
        OP_RD    = 3'd2,
        OP_WR    = 3'd3,
        OP_BST   = 3'd4,
        OP_PRE   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } trk_op_e;

    // Longest fixed burst is 2**MAX_BURST_LOG beats.
    localparam int MAX_BURST_LOG = 3;
    localparam int BEAT_W        = MAX_BURST_LOG;

    // Full-page bursts are any select value beyond the fixed range.
    function automatic logic sel_is_full(input logic [2:0] sel);
        return (sel > 3'(MAX_BURST_LOG));
    endfunction

    // Number of beats left after the first one, for a fixed burst.
    function automatic logic [BEAT_W-1:0] sel_last_beat(input logic [2:0] sel);
        logic [BEAT_W:0] len;
        len = (BEAT_W+1)'(1) << sel[1:0];
        return BEAT_W'(len - 1'b1);
    endfunction

endpackage

// File: rtl/sdram_cmd_router.sv
// Command router: decides whether the presented command is legal,
// steers accepted commands to one bank, remembers which bank took the
// latest READ/WRITE so a burst stop can reach it, and registers the
// error pulse. Assumes the bank status inputs reflect the current cycle.
module sdram_cmd_router
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  trk_op_e              cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [NUM_BANKS-1:0] bank_ready,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_go,
    output logic [NUM_BANKS-1:0] bank_stop,
    output logic                 cmd_error
);

    logic              is_bank_cmd;
    logic              is_rw;
    logic              reject;
    logic [BANK_W-1:0] last_bank_q;
    logic              last_vld_q;

    // Classify the command and decide whether it must be rejected.
    always_comb begin
        is_rw       = (cmd_op == OP_RD) || (cmd_op == OP_WR);
        is_bank_cmd = is_rw || (cmd_op == OP_ACT) || (cmd_op == OP_PRE);
        reject      = cmd_valid && is_bank_cmd &&
                      (!bank_ready[cmd_bank] || (is_rw && !bank_open[cmd_bank]));
    end

    // Steer accepted commands and burst stops to one bank each.
    always_comb begin
        bank_go   = '0;
        bank_stop = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cmd_valid && is_bank_cmd && !reject && (cmd_bank == BANK_W'(b)))
                bank_go[b] = 1'b1;
            if (cmd_valid && (cmd_op == OP_BST) && last_vld_q &&
                (last_bank_q == BANK_W'(b)))
                bank_stop[b] = 1'b1;
        end
    end

    // Remember the bank of the latest accepted READ/WRITE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bank_q <= '0;
            last_vld_q  <= 1'b0;
        end else if (cmd_valid && is_rw && !reject) begin
            last_bank_q <= cmd_bank;
            last_vld_q  <= 1'b1;
        end
    end

    // Register the error pulse for the cycle after a rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_error <= 1'b0;
        else        cmd_error <= reject;
    end

    // R10: an error pulse always follows a presented command.
    assert_err_follows_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> $past(cmd_valid));

    // R8: at most one bank is touched per cycle.
    assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_go | bank_stop));

endmodule

// File: rtl/sdram_bank_state.sv
// Per-bank state: open flag and row, burst beat counter, auto-precharge
// pending flag and precharge recovery down-counter. Assumes the router
// only sends accepted commands (bank ready, and open for READ/WRITE).
module sdram_bank_state
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int T_RP  = 3,
    localparam int RP_W = $clog2(T_RP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  trk_op_e          op,
    input  logic [ROW_W-1:0] row,
    input  logic             auto_pre,
    input  logic [2:0]       burst_sel,
    input  logic             stop,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row,
    output logic             ready
);

    logic              bursting_q;
    logic              full_q;
    logic              ap_q;
    logic [BEAT_W-1:0] beats_q;
    logic [RP_W-1:0]   rp_q;

    // Ready once recovery is over and no auto-precharge burst is running.
    always_comb begin
        ready = (rp_q == '0) && !(bursting_q && ap_q);
    end

    // Advance the burst, apply commands and count the recovery time down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open   <= 1'b0;
            open_row   <= '0;
            bursting_q <= 1'b0;
            full_q     <= 1'b0;
            ap_q       <= 1'b0;
            beats_q    <= '0;
            rp_q       <= '0;
        end else begin
            if (rp_q != '0) rp_q <= rp_q - 1'b1;
            if (stop) begin
                bursting_q <= 1'b0;
                ap_q       <= 1'b0;
            end else if (go) begin
                case (op)
                    OP_ACT: begin
                        if (!row_open) begin
                            row_open <= 1'b1;
                            open_row <= row;
                        end
                    end
                    OP_RD, OP_WR: begin
                        bursting_q <= 1'b1;
                        full_q     <= sel_is_full(burst_sel);
                        ap_q       <= auto_pre && !sel_is_full(burst_sel);
                        beats_q    <= sel_last_beat(burst_sel);
                    end
                    OP_PRE: begin
                        if (row_open) begin
                            row_open   <= 1'b0;
                            bursting_q <= 1'b0;
                            ap_q       <= 1'b0;
                            rp_q       <= RP_W'(T_RP);
                        end
                    end
                    default: ;
                endcase
            end else if (bursting_q && !full_q) begin
                if (beats_q == '0) begin
                    bursting_q <= 1'b0;
                    if (ap_q) begin
                        ap_q     <= 1'b0;
                        row_open <= 1'b0;
                        rp_q     <= RP_W'(T_RP);
                    end
                end else begin
                    beats_q <= beats_q - 1'b1;
                end
            end
        end
    end

    // R4: whenever a row closes the bank enters recovery.
    assert_busy_on_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_open) |-> !ready);

    // R2: the open row is held while the bank stays open.
    assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open && $past(row_open)) |-> $stable(open_row));

    // R8: a burst stop never changes the open state.
    assert_stop_keeps_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(row_open));

    // R7: an untouched full-page burst keeps running with the row open.
    assert_fullpage_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bursting_q && full_q && !go && !stop) |=> (row_open && bursting_q));

endmodule

// File: rtl/sdram_bank_tracker.sv
// Top: one router plus one state tracker per bank. Outputs are the
// per-bank open flags, open rows (flattened) and ready flags, plus the
// registered error pulse. Assumes a single command per cycle.
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int T_RP      = 3,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic                       cmd_auto_pre,
    input  logic [2:0]                 burst_sel,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic [NUM_BANKS-1:0]       bank_ready,
    output logic                       cmd_error
);

    trk_op_e              op_e;
    logic [NUM_BANKS-1:0] go_vec;
    logic [NUM_BANKS-1:0] stop_vec;

    // Map the raw operation code onto the shared enumeration.
    always_comb begin
        op_e = trk_op_e'(cmd_op);
    end

    sdram_cmd_router #(.NUM_BANKS(NUM_BANKS)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_e),
        .cmd_bank   (cmd_bank),
        .bank_ready (bank_ready),
        .bank_open  (bank_open),
        .bank_go    (go_vec),
        .bank_stop  (stop_vec),
        .cmd_error  (cmd_error)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_state #(.ROW_W(ROW_W), .T_RP(T_RP)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .go        (go_vec[b]),
            .op        (op_e),
            .row       (cmd_row),
            .auto_pre  (cmd_auto_pre),
            .burst_sel (burst_sel),
            .stop      (stop_vec[b]),
            .row_open  (bank_open[b]),
            .open_row  (open_row[b*ROW_W +: ROW_W]),
            .ready     (bank_ready[b])
        );
    end

endmodule

// File: tb/sdram_bank_tracker_test.sv
// Directed bench for the bank tracker: one task per scenario.
module sdram_bank_tracker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int RW   = 12;
    localparam int TRP  = 3;
    localparam int BW   = 2;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           BST = 3'd4, PRE = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = NOP;
    logic [BW-1:0]     cmd_bank = '0;
    logic [RW-1:0]     cmd_row = '0;
    logic              cmd_auto_pre = 1'b0;
    logic [2:0]        burst_sel = 3'd2;
    logic [NB-1:0]     bank_open;
    logic [NB*RW-1:0]  open_row;
    logic [NB-1:0]     bank_ready;
    logic              cmd_error;

    int n_run = 0;
    int n_fail = 0;

    sdram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .T_RP(TRP)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_auto_pre(cmd_auto_pre),
        .burst_sel(burst_sel), .bank_open(bank_open), .open_row(open_row),
        .bank_ready(bank_ready), .cmd_error(cmd_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int row_of(input int b);
        return int'(open_row[b*RW +: RW]);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Present one command at a falling edge; returns just after it is taken.
    task automatic issue(input logic [2:0] op, input int b, input int row, input logic ap);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = BW'(b);
        cmd_row = RW'(row); cmd_auto_pre = ap;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = NOP; cmd_auto_pre = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "open after reset", int'(bank_open), 0);
        check("R1", "ready after reset", int'(bank_ready), 15);
        check("R1", "error after reset", int'(cmd_error), 0);
    endtask

    task automatic t_activate();
        issue(ACT, 0, 'h123, 1'b0);
        check("R2", "bank0 open", int'(bank_open[0]), 1);
        check("R2", "bank0 row", row_of(0), 'h123);
        issue(ACT, 0, 'h456, 1'b0);
        check("R2", "second ACTIVE ignored row", row_of(0), 'h123);
    endtask

    task automatic t_plain_read();
        burst_sel = 3'd2;
        issue(RD, 0, 0, 1'b0);
        step(6);
        check("R5", "row open after plain burst", int'(bank_open[0]), 1);
        check("R5", "ready after plain burst", int'(bank_ready[0]), 1);
    endtask

    // Auto-precharge burst of length len on an already open bank.
    task automatic ap_burst(input int b, input logic [2:0] sel, input int len, input string req);
        burst_sel = sel;
        issue(RD, b, 0, 1'b1);
        check(req, "busy during AP burst", int'(bank_ready[b]), 0);
        step(len - 1);
        check(req, "open on last beat", int'(bank_open[b]), 1);
        step(1);
        check(req, "closed after burst", int'(bank_open[b]), 0);
        check(req, "busy at close", int'(bank_ready[b]), 0);
        step(TRP - 1);
        check(req, "busy before recovery ends", int'(bank_ready[b]), 0);
        step(1);
        check(req, "ready after recovery", int'(bank_ready[b]), 1);
    endtask

    task automatic t_ap_timing();
        ap_burst(0, 3'd2, 4, "R4");
        issue(ACT, 0, 'h011, 1'b0);
        ap_burst(0, 3'd0, 1, "R3");
        issue(ACT, 0, 'h012, 1'b0);
        ap_burst(0, 3'd1, 2, "R3");
        issue(ACT, 0, 'h013, 1'b0);
        ap_burst(0, 3'd3, 8, "R3");
    endtask

    task automatic t_no_inherit();
        issue(ACT, 1, 'h0AA, 1'b0);
        ap_burst(1, 3'd2, 4, "R6");
        issue(ACT, 1, 'h0BB, 1'b0);
        issue(WR, 1, 0, 1'b0);
        step(8);
        check("R6", "reopened bank stays open", int'(bank_open[1]), 1);
        check("R6", "reopened row", row_of(1), 'h0BB);
    endtask

    task automatic t_restart();
        burst_sel = 3'd3;
        issue(RD, 1, 0, 1'b0);
        step(2);
        burst_sel = 3'd0;
        issue(RD, 1, 0, 1'b1);
        check("R11", "open during new 1-beat AP burst", int'(bank_open[1]), 1);
        step(1);
        check("R11", "closed by restarted burst", int'(bank_open[1]), 0);
        step(TRP);
        check("R11", "ready after restart close", int'(bank_ready[1]), 1);
    endtask

    task automatic t_full_page();
        burst_sel = 3'd7;
        issue(ACT, 1, 'h321, 1'b0);
        issue(WR, 1, 0, 1'b1);
        step(20);
        check("R7", "full page AP ignored open", int'(bank_open[1]), 1);
        check("R7", "full page ready", int'(bank_ready[1]), 1);
        burst_sel = 3'd5;
        issue(ACT, 2, 'h222, 1'b0);
        issue(RD, 2, 0, 1'b1);
        step(12);
        check("R3", "select 5 is full page", int'(bank_open[2]), 1);
        issue(BST, 0, 0, 1'b0);
        check("R8", "stop keeps full page row", int'(bank_open[2]), 1);
        check("R10", "stop never errors", int'(cmd_error), 0);
    endtask

    task automatic t_stop_ap();
        burst_sel = 3'd3;
        issue(ACT, 3, 'h333, 1'b0);
        issue(RD, 3, 0, 1'b1);
        check("R8", "busy before stop", int'(bank_ready[3]), 0);
        issue(BST, 0, 0, 1'b0);
        check("R8", "ready after stop", int'(bank_ready[3]), 1);
        step(12);
        check("R8", "stop cancels AP close", int'(bank_open[3]), 1);
    endtask

    task automatic t_stop_latest();
        burst_sel = 3'd3;
        issue(ACT, 0, 'h044, 1'b0);
        issue(RD, 0, 0, 1'b1);
        issue(RD, 3, 0, 1'b0);
        issue(BST, 0, 0, 1'b0);
        step(5);
        check("R8", "older AP burst still open", int'(bank_open[0]), 1);
        step(1);
        check("R8", "older AP burst closes on time", int'(bank_open[0]), 0);
        step(TRP);
    endtask

    task automatic t_precharge();
        issue(PRE, 1, 0, 1'b0);
        check("R9", "closed by precharge", int'(bank_open[1]), 0);
        check("R9", "busy after precharge", int'(bank_ready[1]), 0);
        step(TRP - 1);
        check("R9", "still recovering", int'(bank_ready[1]), 0);
        step(1);
        check("R9", "recovered", int'(bank_ready[1]), 1);
        issue(PRE, 1, 0, 1'b0);
        check("R9", "precharge closed bank stays ready", int'(bank_ready[1]), 1);
        check("R9", "precharge closed bank no error", int'(cmd_error), 0);
        burst_sel = 3'd3;
        issue(RD, 2, 0, 1'b0);
        step(2);
        issue(PRE, 2, 0, 1'b0);
        check("R9", "precharge mid burst closes", int'(bank_open[2]), 0);
        step(TRP);
    endtask

    task automatic t_errors();
        issue(RD, 1, 0, 1'b0);
        check("R10", "read closed bank error", int'(cmd_error), 1);
        check("R10", "read closed bank no effect", int'(bank_ready[1]), 1);
        step(1);
        check("R10", "error lasts one cycle", int'(cmd_error), 0);
        issue(PRE, 3, 0, 1'b0);
        issue(ACT, 3, 'h077, 1'b0);
        check("R10", "busy bank error", int'(cmd_error), 1);
        step(TRP);
        check("R10", "rejected ACTIVE no effect", int'(bank_open[3]), 0);
        check("R10", "bank ready after recovery", int'(bank_ready[3]), 1);
        issue(BST, 2, 0, 1'b0);
        check("R10", "idle stop no error", int'(cmd_error), 0);
    endtask

    task automatic t_reset_mid();
        burst_sel = 3'd3;
        issue(ACT, 0, 'h055, 1'b0);
        issue(RD, 0, 0, 1'b1);
        issue(RD, 1, 0, 1'b0);
        do_reset();
        check("R1", "open cleared by reset", int'(bank_open), 0);
        check("R1", "ready after mid reset", int'(bank_ready), 15);
        check("R1", "error cleared by reset", int'(cmd_error), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_activate();
        t_plain_read();
        t_ap_timing();
        t_no_inherit();
        t_restart();
        t_full_page();
        t_stop_ap();
        t_stop_latest();
        t_precharge();
        t_errors();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule